// File: doc/BRIEF.md
# Bulk-In Packet Segmenter

This block sits between a receive frame buffer and a USB transmit engine. It reads stored Ethernet frames one byte per beat and splits each frame, treated as one USB bulk-in transfer, into packets that the engine sends as they are. The largest packet is 512 bytes when the link runs at high speed and 64 bytes at full speed. The speed is a plain level input, so the packet size can change while the block is running.

Each frame ends with one of two kinds of packet. If the frame leaves a partial packet, that short packet closes the transfer. If the frame fills its last packet exactly, the block adds a zero-length marker beat after it so the engine can send an empty packet. Both the buffer side and the engine side use valid/ready handshakes. A beat moves only in a cycle where valid and ready are both high. Either side may hold off the other for any number of cycles. While the engine holds `out_ready` low, the beat on offer does not change.

Top module: `bulk_in_segmenter`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: While `speed_hs` is 1 at the start of each packet, `out_pkt_end` is 1 on every 512th byte of a transfer. No packet carries more than 512 data beats.
- R3: While `speed_hs` is 0 at the start of each packet, `out_pkt_end` is 1 on every 64th byte of a transfer.
- R4: The block samples `speed_hs` on the first byte of each packet. A change partway through a packet leaves that packet's size unchanged and applies from the next packet onward.
- R5: A final packet shorter than the current maximum carries both `out_pkt_end`=1 and `out_last`=1 on its final byte. No other data byte has `out_last`=1.
- R6: When a transfer fills its last packet exactly, that final byte has `out_pkt_end`=1 and `out_last`=0. The next output beat is a marker beat with `out_zlp`=1, `out_last`=1, `out_pkt_end`=1 and `out_data`=0.
- R7: A transfer ends at the earlier of two points: the byte that carries `in_eof`=1, or the byte whose count reaches the `in_len` value sampled with `in_sof`. An `in_len` of 0 or 1 gives a one-byte transfer.
- R8: The block accepts bytes that arrive while no transfer is open and that have `in_sof`=0, then drops them. They produce no output beat.
- R9: While `out_valid` is 1 and `out_ready` is 0, all output fields hold steady. While `out_valid` is 0, `in_ready` is 1.
- R10: The byte count within a packet returns to zero at every packet end and at every transfer end, so each new transfer starts a fresh packet.
- R11: Data bytes leave in the order they were accepted, with their values unchanged, and each accepted in-transfer byte produces exactly one output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| speed_hs | input | 1 | 1 = high speed (512-byte packets), 0 = full speed (64-byte packets) |
| in_valid | input | 1 | Buffer offers a byte |
| in_ready | output | 1 | Block takes the offered byte this cycle |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Final byte of a frame |
| in_len | input | 15 | Frame byte count, sampled with `in_sof` |
| out_valid | output | 1 | Output beat on offer |
| out_ready | input | 1 | Engine takes the beat this cycle |
| out_data | output | 8 | Packet byte (0 on a marker beat) |
| out_pkt_end | output | 1 | Final beat of a packet |
| out_last | output | 1 | Final beat of the transfer |
| out_zlp | output | 1 | Zero-length packet marker beat |

## Verification
Frame lengths are chosen to fall on both sides of the packet edges. Lengths that are exact multiples of 64 and 512 must produce the marker beat, and lengths one byte short or long of those must not, which separates the boundary case from a short final packet. Some frames toggle the speed partway through a packet. These show whether the size is latched at packet start or read live. Other frames end early on `in_eof`, stop on `in_len` with trailing bytes that carry no start flag, or start a new frame right after a short one. Together these tell apart the two end conditions, the discard path, and the counter clearing. Random valid gaps, random ready stalls and random speed toggles run over long frames to check that stalled beats stay put and that no byte is lost or duplicated.

// File: rtl/bis_pkg.sv
package bis_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              pkt_end;
    logic              last;
    logic              zlp;
  } beat_t;
endpackage

// File: rtl/bis_xfer_track.sv
// Tracks whether a transfer is open and how many bytes it may still carry.
module bis_xfer_track #(
  parameter int unsigned LEN_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             sof,
  input  logic             eof,
  input  logic [LEN_W-1:0] len,
  output logic             take,
  output logic             xfer_end
);
  logic             open_q;
  logic [LEN_W-1:0] rem_q;
  logic [LEN_W-1:0] rem_eff;

  always_comb begin
    rem_eff  = open_q ? rem_q : len;
    take     = open_q | sof;
    // R7: whichever end condition comes first closes the transfer
    xfer_end = eof | (rem_eff <= LEN_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rem_q  <= '0;
    end else if (accept && take) begin
      open_q <= !xfer_end;
      rem_q  <= (rem_eff == '0) ? '0 : rem_eff - LEN_W'(1);
    end
  end
endmodule

// File: rtl/bis_blk_track.sv
// Byte position inside the current packet and the speed latched at its start.
module bis_blk_track #(
  parameter int unsigned HS_BLK = 512,
  parameter int unsigned FS_BLK = 64,
  localparam int unsigned CNT_W = $clog2(HS_BLK)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic speed_hs,
  input  logic xfer_end,
  output logic blk_end
);
  localparam logic [CNT_W-1:0] HS_M1 = CNT_W'(HS_BLK - 1);
  localparam logic [CNT_W-1:0] FS_M1 = CNT_W'(FS_BLK - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             hs_q;
  logic             eff_hs;
  logic [CNT_W-1:0] size_m1;

  always_comb begin
    // R4: a fresh packet takes the live speed, an ongoing one keeps its own
    eff_hs  = (cnt_q == '0) ? speed_hs : hs_q;
    size_m1 = eff_hs ? HS_M1 : FS_M1;
    blk_end = (cnt_q == size_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hs_q  <= 1'b0;
    end else if (step) begin
      hs_q  <= eff_hs;
      // R10: count restarts at every packet or transfer end
      cnt_q <= (blk_end || xfer_end) ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/bis_out_stage.sv
// Registered output slot plus a pending zero-length marker.
module bis_out_stage
  import bis_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_v,
  input  beat_t load,
  input  logic  zlp_req,
  input  logic  out_ready,
  output logic  out_valid,
  output beat_t out_beat,
  output logic  can_take
);
  localparam beat_t ZLP_BEAT = '{data: '0, pkt_end: 1'b1, last: 1'b1, zlp: 1'b1};

  logic  valid_q;
  logic  pend_q;
  beat_t beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      beat_q  <= '0;
    end else if (load_v) begin
      valid_q <= 1'b1;
      beat_q  <= load;
      pend_q  <= zlp_req;
    end else if (pend_q && (!valid_q || out_ready)) begin
      valid_q <= 1'b1;
      beat_q  <= ZLP_BEAT;
      pend_q  <= 1'b0;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign out_beat  = beat_q;
  assign can_take  = (!valid_q || out_ready) && !pend_q;
endmodule

// File: rtl/bulk_in_segmenter.sv
module bulk_in_segmenter
  import bis_pkg::*;
#(
  parameter int unsigned HS_BLK   = 512,
  parameter int unsigned FS_BLK   = 64,
  parameter int unsigned RX_BYTES = 20480,
  localparam int unsigned LEN_W   = $clog2(RX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              speed_hs,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [LEN_W-1:0]  in_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_pkt_end,
  output logic              out_last,
  output logic              out_zlp
);
  generate
    if (FS_BLK < 1 || FS_BLK > HS_BLK) begin : g_bad_sizes
      $error("bulk_in_segmenter: FS_BLK must lie in 1..HS_BLK");
    end
  endgenerate

  logic  accept, step, take, xfer_end, blk_end, can_take;
  beat_t nxt_beat, cur_beat;

  assign in_ready = can_take;
  assign accept   = in_valid && can_take;
  assign step     = accept && take;   // R8: out-of-transfer bytes are consumed only

  bis_xfer_track #(.LEN_W(LEN_W)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .sof      (in_sof),
    .eof      (in_eof),
    .len      (in_len),
    .take     (take),
    .xfer_end (xfer_end)
  );

  bis_blk_track #(.HS_BLK(HS_BLK), .FS_BLK(FS_BLK)) u_blk (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .speed_hs (speed_hs),
    .xfer_end (xfer_end),
    .blk_end  (blk_end)
  );

  always_comb begin
    nxt_beat.data    = in_data;
    nxt_beat.pkt_end = blk_end | xfer_end;
    nxt_beat.last    = xfer_end & ~blk_end;  // R5: short closing packet
    nxt_beat.zlp     = 1'b0;
  end

  bis_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_v    (step),
    .load      (nxt_beat),
    .zlp_req   (xfer_end & blk_end),          // R6: exact fill needs a marker
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_beat  (cur_beat),
    .can_take  (can_take)
  );

  assign out_data    = cur_beat.data;
  assign out_pkt_end = cur_beat.pkt_end;
  assign out_last    = cur_beat.last;
  assign out_zlp     = cur_beat.zlp;
endmodule

// File: rtl/bis_checker.sv
module bis_checker #(
  parameter int unsigned HS_BLK = 512
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_pkt_end,
  input logic       out_last,
  input logic       out_zlp
);
  localparam int unsigned CW = $clog2(HS_BLK) + 1;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (out_valid && out_ready) run_q <= out_pkt_end ? '0 : run_q + CW'(1);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (!out_valid && in_ready); // R1
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_pkt_end)
      && $stable(out_last) && $stable(out_zlp)); // R9

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R9

  AST_ZLP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_zlp |-> out_last && out_pkt_end && out_data == 8'h00); // R6

  AST_LAST_ENDS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> out_pkt_end); // R5

  AST_NO_OVERSIZE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && run_q == CW'(HS_BLK - 1) |-> out_pkt_end); // R2
endmodule

bind bulk_in_segmenter bis_checker #(.HS_BLK(HS_BLK)) u_chk (.*);

// File: tb/bulk_in_segmenter_bench.sv
`timescale 1ns/1ps
module bulk_in_segmenter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        speed_hs = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic [14:0] in_len = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_pkt_end, out_last, out_zlp;

  always #2 clk = ~clk;

  bulk_in_segmenter u_bulk_in_segmenter (.*);

  typedef struct { logic [7:0] d; logic pe; logic la; logic z; } exp_t;
  exp_t q[$];

  int checks = 0, failures = 0;
  int beats = 0, pkts = 0, lasts = 0, zlps = 0;
  int rdy_pct = 100, gap_pct = 0;
  bit spd_jit = 0, acc = 0;
  logic       s_valid = 0, s_sof = 0, s_eof = 0;
  logic [7:0] s_data = 0;
  logic [14:0] s_len = 0;
  bit stall_p = 0;
  logic [7:0] p_d; logic p_pe, p_la, p_z;

  // reference model state
  bit m_open = 0, m_hs = 0;
  int m_cnt = 0, m_rem = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    exp_t e;
    int rem_eff, size;
    bit first, bend, xend;
    if (!m_open && !in_sof) return;           // R8 discard
    first = !m_open;
    if (first) m_cnt = 0;
    rem_eff = first ? int'(in_len) : m_rem;
    if (m_cnt == 0) m_hs = speed_hs;          // R4 sample at packet start
    size = m_hs ? 512 : 64;
    bend = (m_cnt == size - 1);
    xend = in_eof || rem_eff <= 1;            // R7
    e.d = in_data; e.pe = bend || xend; e.la = xend && !bend; e.z = 0;
    q.push_back(e);
    if (xend && bend) begin
      e.d = 0; e.pe = 1; e.la = 1; e.z = 1;
      q.push_back(e);
    end
    m_cnt  = (bend || xend) ? 0 : m_cnt + 1;
    m_rem  = (rem_eff == 0) ? 0 : rem_eff - 1;
    m_open = !xend;
  endtask

  task automatic cycle();
    exp_t e;
    @(negedge clk);
    in_valid = s_valid; in_data = s_data; in_sof = s_sof; in_eof = s_eof; in_len = s_len;
    out_ready = ($urandom_range(99) < rdy_pct);
    if (spd_jit && $urandom_range(99) < 2) speed_hs = ~speed_hs;
    #1;
    if (stall_p) begin
      chk(out_valid == 1'b1, "R9", "stalled beat dropped", out_valid, 1);
      chk({out_data, out_pkt_end, out_last, out_zlp} == {p_d, p_pe, p_la, p_z},
          "R9", "stalled beat changed", {out_data, out_pkt_end, out_last, out_zlp},
          {p_d, p_pe, p_la, p_z});
    end
    if (out_valid && out_ready) begin
      beats++; pkts += out_pkt_end; lasts += out_last; zlps += out_zlp;
      if (q.size() == 0) begin
        chk(0, "R11", "unexpected output beat", 1, 0);
      end else begin
        e = q.pop_front();
        chk(out_data == e.d, "R11", "data", out_data, e.d);
        chk(out_pkt_end == e.pe, "R2 R3", "pkt_end", out_pkt_end, e.pe);
        chk(out_last == e.la, "R5", "last", out_last, e.la);
        chk(out_zlp == e.z, "R6", "zlp", out_zlp, e.z);
      end
    end
    stall_p = out_valid && !out_ready;
    p_d = out_data; p_pe = out_pkt_end; p_la = out_last; p_z = out_zlp;
    acc = in_valid && in_ready;
    if (acc) model_step();
  endtask

  task automatic push_byte(bit sof, bit eof, int len);
    while ($urandom_range(99) < gap_pct) begin s_valid = 0; cycle(); end
    s_valid = 1; s_data = 8'($urandom); s_sof = sof; s_eof = eof; s_len = 15'(len);
    do cycle(); while (!acc);
    s_valid = 0;
  endtask

  task automatic send_frame(int n, int len, int eof_at);
    for (int i = 0; i < n; i++) push_byte(i == 0, (i + 1) == eof_at, len);
  endtask

  task automatic drain();
    int keep;
    keep = rdy_pct; rdy_pct = 100;
    s_valid = 0;
    repeat (6) cycle();
    rdy_pct = keep;
  endtask

  initial begin
    int b0, p0, z0, l0, n;
    void'($urandom(32'h5eed_0b1c));
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
    chk(in_ready == 1, "R1", "in_ready in reset", in_ready, 1);
    @(negedge clk); rst_n = 1'b1; #1;
    chk(out_valid == 0 && in_ready == 1, "R1", "idle after reset",
        {out_valid, in_ready}, 2'b01);

    rdy_pct = 60; gap_pct = 20;

    // R3 R6: full-speed exact fill gives a marker
    speed_hs = 0; z0 = zlps; p0 = pkts;
    send_frame(64, 64, 64); drain();
    chk(zlps - z0 == 1, "R6", "marker after exact 64", zlps - z0, 1);
    chk(pkts - p0 == 2, "R3", "packets for 64 bytes", pkts - p0, 2);

    // R3 R5: one short of the edge
    p0 = pkts; z0 = zlps; l0 = lasts;
    send_frame(63, 63, 63); drain();
    chk(pkts - p0 == 1 && zlps == z0, "R5", "short 63 packets", pkts - p0, 1);
    chk(lasts - l0 == 1, "R5", "one last for 63", lasts - l0, 1);

    // R2: high speed 1000 bytes, 512 + 488
    speed_hs = 1; p0 = pkts; z0 = zlps;
    send_frame(1000, 1000, 1000); drain();
    chk(pkts - p0 == 2 && zlps == z0, "R2", "packets for 1000 HS", pkts - p0, 2);
    z0 = zlps;
    send_frame(512, 512, 512); drain();
    chk(zlps - z0 == 1, "R6", "marker after exact 512", zlps - z0, 1);

    // R4: speed drops after 100 bytes of a 600-byte frame -> 512, 64, 24
    speed_hs = 1; p0 = pkts;
    for (int i = 0; i < 600; i++) begin
      if (i == 100) speed_hs = 0;
      push_byte(i == 0, i == 599, 600);
    end
    drain();
    chk(pkts - p0 == 3, "R4", "mid-packet drop to FS", pkts - p0, 3);
    // R4: speed rises after 10 bytes of a 100-byte frame -> 64, 36
    speed_hs = 0; p0 = pkts;
    for (int i = 0; i < 100; i++) begin
      if (i == 10) speed_hs = 1;
      push_byte(i == 0, i == 99, 100);
    end
    drain();
    chk(pkts - p0 == 2, "R4", "mid-packet rise to HS", pkts - p0, 2);

    // R7: eof before the length
    speed_hs = 0; b0 = beats; l0 = lasts;
    send_frame(5, 10, 5); drain();
    chk(beats - b0 == 5 && lasts - l0 == 1, "R7", "eof ends early", beats - b0, 5);
    // R7 R8: length runs out, trailing non-sof bytes dropped
    b0 = beats; l0 = lasts;
    send_frame(5, 3, 0); drain();
    chk(beats - b0 == 3, "R8", "trailing bytes dropped", beats - b0, 3);
    chk(lasts - l0 == 1, "R7", "length ends transfer", lasts - l0, 1);
    // R7: length of zero is one byte
    b0 = beats;
    send_frame(1, 0, 0); drain();
    chk(beats - b0 == 1, "R7", "zero length one byte", beats - b0, 1);

    // R10: short frame then exact frame must start a fresh packet
    z0 = zlps;
    send_frame(30, 30, 30);
    send_frame(64, 64, 64); drain();
    chk(zlps - z0 == 1, "R10", "count cleared between frames", zlps - z0, 1);

    // random traffic
    rdy_pct = 70; gap_pct = 30; spd_jit = 1;
    for (int f = 0; f < 40; f++) begin
      n = ($urandom_range(3) == 0) ? 64 * $urandom_range(1, 16) : $urandom_range(1, 1300);
      send_frame(n, n, n);
    end
    spd_jit = 0;
    drain();
    chk(q.size() == 0, "R11", "beats left undelivered", q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    failures++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule